// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block sequences legacy IDE programmed-I/O transfers for two channels with two drives each. A transfer request names a channel, a drive, a direction and whether it targets the command block. The block then runs three phases in turn. First an address-setup phase, then an active phase in which the read or write strobe of the addressed channel is driven low, then a recovery phase. It raises `done` in the last recovery cycle and returns to idle.

Phase lengths come from timing registers. Software loads these through a byte-wide write port. Each primary-channel drive has its own setup register and its own read/write timing register. The two secondary-channel drives share one pair. Command-block accesses use a separate command timing byte with a fixed setup phase that uses the slowest setup length. A revision input stretches recovery by one clock on later silicon revisions. The secondary channel accepts requests only while its enable bit is set.

Top module: `ide_pio_strobe_gen`

## Requirements
- R1: After reset the block is idle: `busy` and `done` are low and all four strobes are high. Every drive's timing is 4 setup, 16 active and 16 recovery clocks (plus the revision extension), the secondary channel is disabled, and the command timing byte is 0.
- R2: Setup length is decoded from bits 7:6 of the drive's setup register: 00 gives 4 clocks, 01 gives 2, 10 gives 3 and 11 gives 5.
- R3: The active length is the upper nibble of the drive's read/write timing byte, where 0 means 16. A value of 1 is raised to 2, so the strobe is never low for fewer than 2 clocks.
- R4: The recovery length is the lower nibble of the read/write timing byte, where 0 means 16.
- R5: When `rev_id` is greater than 1, recovery lasts one clock more than the nibble gives.
- R6: An accepted request gives `busy` high for exactly setup+active+recovery cycles, in that phase order. `done` is high only in the final recovery cycle, and every strobe is high whenever `busy` is low.
- R7: A request that arrives while `busy` is high is ignored. It is not queued and starts no later transfer.
- R8: Register addresses are: 2/3 for drive 0 setup/timing on the primary channel, 4/5 for drive 1, and 6/7 for the shared secondary pair. The two primary drives use independent registers, and both secondary drives use the shared pair.
- R9: A request to channel 1 is dropped (no `busy`, no strobe) unless bit 3 of the control register (address 0) is set.
- R10: A command-block request (`req_cmd`=1) uses 5 setup clocks. Its active and recovery lengths come from the upper and lower nibbles of the command timing byte (address 1), with 0 meaning 16, so writing 0 selects the slowest timing.
- R11: During the active phase only one strobe is low: `dior_n[chan]` for a read, or `diow_n[chan]` for a write.
- R12: Timing is captured when the request is accepted. Register writes during a transfer affect only later transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 8 | Register write data |
| rev_id | input | 2 | Silicon revision; values above 1 extend recovery |
| req_valid | input | 1 | Transfer request |
| req_chan | input | 1 | Channel: 0 primary, 1 secondary |
| req_drive | input | 1 | Drive within the channel |
| req_write | input | 1 | 1 write, 0 read |
| req_cmd | input | 1 | Command-block access |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Final recovery cycle |
| dior_n | output | 2 | Read strobes per channel, active low |
| diow_n | output | 2 | Write strobes per channel, active low |

## Verification
A wrong decode or a stale phase counter shows up as a setup, strobe or recovery phase of the wrong length. That error is visible on the strobes within the same transfer, one clock off at the first wrong phase boundary. A wrong register slot or channel latch puts the strobe on the wrong pin, or gives the other drive's timing, on the first transfer that follows. A lost idle state shows as `busy` stuck high, or as a second transfer starting without a request, within a few cycles after `done`.

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;

    localparam int CNT_W = 5;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ACTIVE,
        PH_RECOV
    } phase_e;

    typedef struct packed {
        cnt_t setup;
        cnt_t active;
        cnt_t recov;
    } timing_t;

    // register addresses
    localparam int RA_CTRL      = 0;
    localparam int RA_CMD_TIM   = 1;
    localparam int RA_SLOT_BASE = 2;
    localparam int SEC_EN_BIT   = 3;

    function automatic cnt_t setup_clocks(input logic [1:0] code);
        cnt_t v;
        case (code)
            2'b00:   v = cnt_t'(4);
            2'b10:   v = cnt_t'(3);
            2'b01:   v = cnt_t'(2);
            default: v = cnt_t'(5);
        endcase
        return v;
    endfunction

    function automatic cnt_t nib_clocks(input logic [3:0] nib);
        return (nib == 4'd0) ? cnt_t'(16) : cnt_t'(nib);
    endfunction

    function automatic cnt_t active_clocks(input logic [3:0] nib);
        cnt_t v;
        v = nib_clocks(nib);
        return (v < cnt_t'(2)) ? cnt_t'(2) : v;
    endfunction

    function automatic cnt_t recov_clocks(input logic [3:0] nib, input logic late);
        return nib_clocks(nib) + cnt_t'(late);
    endfunction

endpackage

// File: rtl/ide_timing_regs.sv
module ide_timing_regs
    import ide_pio_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int NSLOT  = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [7:0]            wdata,
    output logic                  sec_en,
    output logic [7:0]            cmd_tim,
    output logic [NSLOT-1:0][1:0] set_code,
    output logic [NSLOT-1:0][7:0] rw_tim
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sec_en  <= 1'b0;
            cmd_tim <= 8'h00;
        end else if (we) begin
            if (addr == ADDR_W'(RA_CTRL))    sec_en  <= wdata[SEC_EN_BIT];
            if (addr == ADDR_W'(RA_CMD_TIM)) cmd_tim <= wdata;
        end
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam int SET_A = RA_SLOT_BASE + 2 * g;
        localparam int TIM_A = SET_A + 1;
        logic [1:0] code_q;
        logic [7:0] tim_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                code_q <= 2'b00;
                tim_q  <= 8'h00;
            end else if (we) begin
                if (addr == ADDR_W'(SET_A)) code_q <= wdata[7:6];
                if (addr == ADDR_W'(TIM_A)) tim_q  <= wdata;
            end
        end

        assign set_code[g] = code_q;
        assign rw_tim[g]   = tim_q;
    end

endmodule

// File: rtl/ide_timing_select.sv
module ide_timing_select
    import ide_pio_pkg::*;
#(
    parameter int NSLOT     = 3,
    parameter int REV_W     = 2,
    parameter int LATE_REV  = 1,
    parameter int CMD_SETUP = 5
) (
    input  logic                  chan,
    input  logic                  drive,
    input  logic                  cmd,
    input  logic [REV_W-1:0]      rev,
    input  logic [7:0]            cmd_tim,
    input  logic [NSLOT-1:0][1:0] set_code,
    input  logic [NSLOT-1:0][7:0] rw_tim,
    output timing_t               tim
);

    localparam int SLOT_W = $clog2(NSLOT);
    localparam int SEC_SLOT = NSLOT - 1;

    logic [SLOT_W-1:0] slot;
    logic              late;
    logic [7:0]        tbyte;

    always_comb begin
        slot  = chan ? SLOT_W'(SEC_SLOT) : SLOT_W'(drive);
        late  = (rev > REV_W'(LATE_REV));
        tbyte = cmd ? cmd_tim : rw_tim[slot];
        tim.setup  = cmd ? cnt_t'(CMD_SETUP) : setup_clocks(set_code[slot]);
        tim.active = active_clocks(tbyte[7:4]);
        tim.recov  = recov_clocks(tbyte[3:0], late);
    end

endmodule

// File: rtl/ide_phase_seq.sv
module ide_phase_seq
    import ide_pio_pkg::*;
#(
    parameter int NCHAN = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  timing_t          tim,
    input  logic             chan,
    input  logic             wr,
    output logic             busy,
    output logic             done,
    output logic [NCHAN-1:0] dior_n,
    output logic [NCHAN-1:0] diow_n
);

    phase_e  phase;
    cnt_t    cnt;
    timing_t tim_q;
    logic    chan_q;
    logic    wr_q;
    logic    last;

    assign last = (cnt == cnt_t'(0));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            tim_q  <= '0;
            chan_q <= 1'b0;
            wr_q   <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: if (start) begin
                    phase  <= PH_SETUP;
                    cnt    <= tim.setup - cnt_t'(1);
                    tim_q  <= tim;
                    chan_q <= chan;
                    wr_q   <= wr;
                end
                PH_SETUP: if (last) begin
                    phase <= PH_ACTIVE;
                    cnt   <= tim_q.active - cnt_t'(1);
                end else cnt <= cnt - cnt_t'(1);
                PH_ACTIVE: if (last) begin
                    phase <= PH_RECOV;
                    cnt   <= tim_q.recov - cnt_t'(1);
                end else cnt <= cnt - cnt_t'(1);
                default: if (last) phase <= PH_IDLE;
                         else cnt <= cnt - cnt_t'(1);
            endcase
        end
    end

    assign busy = (phase != PH_IDLE);
    assign done = (phase == PH_RECOV) && last;

    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        logic hit;
        assign hit       = (phase == PH_ACTIVE) && (chan_q == 1'(c));
        assign dior_n[c] = !(hit && !wr_q);
        assign diow_n[c] = !(hit && wr_q);
    end

endmodule

// File: rtl/ide_pio_strobe_gen.sv
module ide_pio_strobe_gen
    import ide_pio_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int REV_W     = 2,
    parameter int LATE_REV  = 1,
    parameter int CMD_SETUP = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic [REV_W-1:0]  rev_id,
    input  logic              req_valid,
    input  logic              req_chan,
    input  logic              req_drive,
    input  logic              req_write,
    input  logic              req_cmd,
    output logic              busy,
    output logic              done,
    output logic [1:0]        dior_n,
    output logic [1:0]        diow_n
);

    localparam int NCHAN = 2;
    localparam int NSLOT = 3;

    logic                  sec_en;
    logic [7:0]            cmd_tim;
    logic [NSLOT-1:0][1:0] set_code;
    logic [NSLOT-1:0][7:0] rw_tim;
    timing_t               tim;
    logic                  accept;

    ide_timing_regs #(.ADDR_W(ADDR_W), .NSLOT(NSLOT)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .sec_en   (sec_en),
        .cmd_tim  (cmd_tim),
        .set_code (set_code),
        .rw_tim   (rw_tim)
    );

    ide_timing_select #(
        .NSLOT(NSLOT), .REV_W(REV_W), .LATE_REV(LATE_REV), .CMD_SETUP(CMD_SETUP)
    ) u_sel (
        .chan     (req_chan),
        .drive    (req_drive),
        .cmd      (req_cmd),
        .rev      (rev_id),
        .cmd_tim  (cmd_tim),
        .set_code (set_code),
        .rw_tim   (rw_tim),
        .tim      (tim)
    );

    assign accept = req_valid && !busy && (!req_chan || sec_en);

    ide_phase_seq #(.NCHAN(NCHAN)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (accept),
        .tim    (tim),
        .chan   (req_chan),
        .wr     (req_write),
        .busy   (busy),
        .done   (done),
        .dior_n (dior_n),
        .diow_n (diow_n)
    );

endmodule

// File: rtl/ide_pio_strobe_gen_chk.sv
module ide_pio_strobe_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic       req_valid,
    input logic       req_chan,
    input logic       sec_en,
    input logic [1:0] dior_n,
    input logic [1:0] diow_n
);

    logic strb;
    assign strb = ~&{dior_n, diow_n};

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $countones({~dior_n, ~diow_n}) <= 1);                          // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !strb);                                              // R6
    AST_DONE_IN_XFER: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);                                                // R6
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);                                               // R6
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);                                     // R7
    AST_ACTIVE_MIN2: assert property (@(posedge clk) disable iff (rst)
        $rose(strb) |=> strb);                                         // R3
    AST_SEC_GATED: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && req_chan && !sec_en) |=> !busy);        // R9

endmodule

bind ide_pio_strobe_gen ide_pio_strobe_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .done      (done),
    .req_valid (req_valid),
    .req_chan  (req_chan),
    .sec_en    (sec_en),
    .dior_n    (dior_n),
    .diow_n    (diow_n)
);

// File: tb/ide_pio_strobe_gen_tb.sv
module ide_pio_strobe_gen_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [1:0] rev_id = 2'd1;
    logic       req_valid = 1'b0;
    logic       req_chan = 1'b0;
    logic       req_drive = 1'b0;
    logic       req_write = 1'b0;
    logic       req_cmd = 1'b0;
    logic       busy, done;
    logic [1:0] dior_n, diow_n;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    int m_s, m_a, m_r, m_tot;
    bit m_done_ok, m_strb_ok, m_late_busy;

    always #(CLK_PERIOD/2) clk = ~clk;

    ide_pio_strobe_gen u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rev_id(rev_id), .req_valid(req_valid),
        .req_chan(req_chan), .req_drive(req_drive), .req_write(req_write),
        .req_cmd(req_cmd), .busy(busy), .done(done),
        .dior_n(dior_n), .diow_n(diow_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int e_setup(input int code);
        case (code)
            0: return 4;
            1: return 2;
            2: return 3;
            default: return 5;
        endcase
    endfunction

    function automatic int e_act(input int n);
        if (n == 0) return 16;
        return (n < 2) ? 2 : n;
    endfunction

    function automatic int e_rec(input int n, input int rev);
        return ((n == 0) ? 16 : n) + ((rev > 1) ? 1 : 0);
    endfunction

    task automatic wr_reg(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 8'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // mode 0 plain, 1 register write mid-transfer, 2 extra request mid-transfer
    task automatic xfer(input bit ch, input bit dv, input bit wr, input bit cmd, input int mode);
        int phase;
        int done_cnt;
        bit last_done;
        logic [3:0] low;
        logic [3:0] mask;
        m_s = 0; m_a = 0; m_r = 0; m_tot = 0;
        m_strb_ok = 1'b1; m_late_busy = 1'b0;
        done_cnt = 0; last_done = 1'b0; phase = 0;
        mask = 4'(1 << (int'(wr) * 2 + int'(ch)));
        @(negedge clk);
        req_chan = ch; req_drive = dv; req_write = wr; req_cmd = cmd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy && m_tot < 100) begin
            low = ~{diow_n, dior_n};
            if (low != 4'b0) begin
                phase = 1; m_a++;
                if (low != mask) m_strb_ok = 1'b0;
            end else if (phase == 0) m_s++;
            else m_r++;
            last_done = done;
            if (done) done_cnt++;
            if (mode == 1 && m_tot == 0) begin
                cfg_we = 1'b1; cfg_addr = 4'd3; cfg_wdata = 8'h11;
            end
            if (mode == 1 && m_tot == 1) cfg_we = 1'b0;
            if (mode == 2 && m_tot == 1) begin
                req_chan = 1'b0; req_drive = 1'b0; req_cmd = 1'b0; req_valid = 1'b1;
            end
            if (mode == 2 && m_tot == 2) req_valid = 1'b0;
            m_tot++;
            @(negedge clk);
        end
        cfg_we = 1'b0; req_valid = 1'b0;
        m_done_ok = (done_cnt == 1) && last_done;
        for (int i = 0; i < 4; i++) begin
            if (busy) m_late_busy = 1'b1;
            @(negedge clk);
        end
    endtask

    task automatic chk_xfer(input string tag, input int es, input int ea, input int er);
        chk({tag, " setup"}, m_s, es);
        chk({tag, " active"}, m_a, ea);
        chk({tag, " recovery"}, m_r, er);
        chk({tag, " R6 done in last cycle"}, int'(m_done_ok), 1);
        chk({tag, " R11 strobe pin"}, int'(m_strb_ok), 1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin : main
        int an[5] = '{0, 1, 2, 7, 15};
        int rn[4] = '{0, 1, 2, 9};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 strobes", int'({dior_n, diow_n}), 15);
        xfer(1'b0, 1'b0, 1'b0, 1'b0, 0);
        chk_xfer("R1 default drive0", 4, 16, 16);
        xfer(1'b0, 1'b1, 1'b1, 1'b0, 0);
        chk_xfer("R1 default drive1", 4, 16, 16);
        xfer(1'b1, 1'b0, 1'b0, 1'b0, 0);
        chk("R1 R9 secondary off at reset", m_tot, 0);

        // R2 R3 R4 R5 sweep on drive 0
        for (int rv = 1; rv <= 2; rv++) begin
            rev_id = 2'(rv);
            for (int c = 0; c < 4; c++)
                for (int i = 0; i < 5; i++)
                    for (int j = 0; j < 4; j++) begin
                        wr_reg(2, c << 6);
                        wr_reg(3, (an[i] << 4) | rn[j]);
                        xfer(1'b0, 1'b0, 1'((c + i + j) & 1), 1'b0, 0);
                        chk_xfer("R2 R3 R4 R5 sweep", e_setup(c), e_act(an[i]), e_rec(rn[j], rv));
                    end
        end
        rev_id = 2'd3;
        xfer(1'b0, 1'b0, 1'b0, 1'b0, 0);
        chk_xfer("R5 rev3", 5, 15, 10);
        rev_id = 2'd0;
        xfer(1'b0, 1'b0, 1'b0, 1'b0, 0);
        chk_xfer("R5 rev0", 5, 15, 9);
        rev_id = 2'd1;

        // R8 independent primary drives, shared secondary pair
        wr_reg(2, 8'h80); wr_reg(3, 8'h23);
        wr_reg(4, 8'hC0); wr_reg(5, 8'h45);
        xfer(1'b0, 1'b0, 1'b1, 1'b0, 0);
        chk_xfer("R8 drive0", 3, 2, 3);
        xfer(1'b0, 1'b1, 1'b0, 1'b0, 0);
        chk_xfer("R8 drive1", 5, 4, 5);
        wr_reg(0, 8'hF7);
        xfer(1'b1, 1'b0, 1'b0, 1'b0, 0);
        chk("R9 bit3 clear rejects", m_tot, 0);
        chk("R9 no late busy", int'(m_late_busy), 0);
        wr_reg(0, 8'h08);
        wr_reg(6, 8'h80); wr_reg(7, 8'h36);
        xfer(1'b1, 1'b0, 1'b0, 1'b0, 0);
        chk_xfer("R8 R9 secondary drive0", 3, 3, 6);
        xfer(1'b1, 1'b1, 1'b1, 1'b0, 0);
        chk_xfer("R8 secondary drive1 shared", 3, 3, 6);
        xfer(1'b0, 1'b0, 1'b0, 1'b0, 0);
        chk_xfer("R8 drive0 unchanged", 3, 2, 3);
        wr_reg(0, 8'h00);
        xfer(1'b1, 1'b1, 1'b0, 1'b0, 0);
        chk("R9 disabled again", m_tot, 0);

        // R10 command timing
        xfer(1'b0, 1'b0, 1'b0, 1'b1, 0);
        chk_xfer("R10 cmd slowest", 5, 16, 16);
        wr_reg(1, 8'h34);
        xfer(1'b0, 1'b1, 1'b1, 1'b1, 0);
        chk_xfer("R10 cmd programmed", 5, 3, 4);

        // R7 request during busy ignored
        xfer(1'b0, 1'b0, 1'b0, 1'b0, 2);
        chk_xfer("R7 first transfer", 3, 2, 3);
        chk("R7 no queued transfer", int'(m_late_busy), 0);

        // R12 timing captured at accept
        wr_reg(3, 8'h58);
        xfer(1'b0, 1'b0, 1'b1, 1'b0, 1);
        chk_xfer("R12 old timing kept", 3, 5, 8);
        xfer(1'b0, 1'b0, 1'b0, 1'b0, 0);
        chk_xfer("R12 R3 new timing", 3, 2, 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule